// File: doc/BRIEF.md
# Dead/Live Bin Learner with Bypass Decision

This block learns which lines are worth keeping in an exclusive last-level cache. When the L2 evicts a line, the line carries a 1-bit trip count and a 2-bit L2 use count. Together these put the line in one of eight bins. A small group of observer sets reports two kinds of event: a fill into an observer set, and a hit in an observer set. Each event carries the bin of the line it affected. For each bin the block keeps two counters. One is a live counter. The other is a dead-minus-live counter, which counts fills minus twice the hits. A periodic halving tick shrinks every counter so that the learned state follows changes in program phase.

For each eviction presented on the decision inputs, the block answers in the same cycle. It says whether the fill into the last-level cache should be skipped (bypass). If the line is not skipped, it gives the 2-bit insertion age for the replacement logic. A skip request becomes a normal fill at age 0 when the target set still has a free way. The cache arrays and the set and way selection belong to the surrounding logic.

Top module: `bin_bypass_learner`

## Requirements
- R1: The bin index is {trip count, use count}, trip count in the most significant bit, giving bins 0 to 7. All learning and decisions for a line use the counters of its bin.
- R2: An observer fill adds 1 to the dead-minus-live counter of its bin.
- R3: An observer hit adds 1 to the live counter of its bin and subtracts 2 from the dead-minus-live counter of that bin. A fill and a hit to the same bin in one cycle change the dead-minus-live counter by -1.
- R4: The live counter is unsigned and saturates at 2^CNT_W-1. The dead-minus-live counter is two's complement and saturates at -2^(CNT_W-1) and 2^(CNT_W-1)-1.
- R5: A halving tick shifts every live counter right by one and every dead-minus-live counter arithmetically right by one (so -3 becomes -2). Fill and hit events in the same cycle are added to the halved values.
- R6: Let dl and l be the counters of the evicted line's bin. A skip is wanted when 2*dl exceeds the sum of the smallest and largest dead-minus-live counters across all bins, and also 2*l is below the sum of the smallest and largest live counters.
- R7: A skip is also wanted when 4*dl exceeds 3 times the sum of all eight dead-minus-live counters.
- R8: If a skip is wanted and the set-has-invalid input is high, bypass stays 0 and the insertion age is 0.
- R9: When no skip is wanted, the age is 3 if 4*l exceeds 3 times the sum of all live counters and the use count is nonzero.
- R10: Otherwise, the age is 0 when the bin's dead count minus 8 times its live count is positive. The dead count is fills minus hits, that is dl+l, so the test is dl-7*l > 0.
- R11: Otherwise, the age is 3 for trip count 1 and 1 for trip count 0.
- R12: The decision depends only on the current inputs and counter values. Counter updates are seen by decisions from the next cycle on. With no eviction valid, bypass and age are 0, and whenever bypass is 1 the age is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all counters |
| obs_fill_valid | input | 1 | Fill into an observer set this cycle |
| obs_fill_tc | input | 1 | Trip count of the filled line |
| obs_fill_uc | input | 2 | Use count of the filled line |
| obs_hit_valid | input | 1 | Hit in an observer set this cycle |
| obs_hit_tc | input | 1 | Trip count of the hit line |
| obs_hit_uc | input | 2 | Use count of the hit line |
| halve_tick | input | 1 | Halve every counter this cycle |
| evict_valid | input | 1 | An L2 eviction needs a decision |
| evict_tc | input | 1 | Trip count of the evicted line |
| evict_uc | input | 2 | Use count of the evicted line |
| set_has_invalid | input | 1 | The target last-level set holds a free way |
| bypass | output | 1 | Skip the last-level fill |
| ins_age | output | 2 | Insertion age when the line is filled |

## Verification
Bypass and age depend only on the inputs and the counters, so each decision is due in the cycle its eviction is presented. An observer event or halving tick in cycle N is first seen by decisions in cycle N+1. The bench drives every input 1 ns after a rising edge and checks at the following falling edge, when the combinational answer has settled. Its reference model first computes the expected decision from the counters as they stood before the current cycle's events, and only then applies those events, so events and evictions in the same cycle are ordered as the design orders them.

// File: rtl/bin_learner_pkg.sv
package bin_learner_pkg;
    localparam int TC_W     = 1;
    localparam int UC_W     = 2;
    localparam int BIN_W    = TC_W + UC_W;
    localparam int NUM_BINS = 1 << BIN_W;
    localparam int AGE_W    = 2;

    localparam logic [AGE_W-1:0] AGE_EVICT_FIRST = 2'd0;
    localparam logic [AGE_W-1:0] AGE_COLD        = 2'd1;
    localparam logic [AGE_W-1:0] AGE_PROTECT     = 2'd3;

    typedef struct packed {
        logic             bypass;
        logic [AGE_W-1:0] age;
    } decision_t;

    function automatic logic [BIN_W-1:0] make_bin(input logic [TC_W-1:0] tc,
                                                   input logic [UC_W-1:0] uc);
        return {tc, uc};
    endfunction
endpackage

// File: rtl/bin_counter_bank.sv
module bin_counter_bank
    import bin_learner_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               fill_v,
    input  logic [BIN_W-1:0]                   fill_bin,
    input  logic                               hit_v,
    input  logic [BIN_W-1:0]                   hit_bin,
    input  logic                               halve,
    output logic [NUM_BINS-1:0][CNT_W-1:0]     live_o,
    output logic [NUM_BINS-1:0][CNT_W-1:0]     dl_o
);
    localparam int XW = CNT_W + 2;
    localparam logic signed [XW-1:0] L_MAX = XW'((longint'(1) << CNT_W) - 1);
    localparam logic signed [XW-1:0] D_MAX = XW'((longint'(1) << (CNT_W - 1)) - 1);
    localparam logic signed [XW-1:0] D_MIN = -D_MAX - XW'(1);

    typedef struct packed {
        logic [NUM_BINS-1:0][CNT_W-1:0] live;
        logic [NUM_BINS-1:0][CNT_W-1:0] dl;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        logic signed [XW-1:0] base_l, base_d, inc_l, delta_d, nxt_l, nxt_d;
        logic                 hit_here, fill_here;
        st_d = st_q;
        for (int b = 0; b < NUM_BINS; b++) begin
            hit_here  = hit_v  && (hit_bin  == BIN_W'(b));
            fill_here = fill_v && (fill_bin == BIN_W'(b));
            base_l = $signed(XW'(st_q.live[b]));
            base_d = $signed(XW'($signed(st_q.dl[b])));
            if (halve) begin
                base_l = base_l >>> 1;
                base_d = base_d >>> 1;
            end
            inc_l   = '0;
            delta_d = '0;
            if (hit_here) begin
                inc_l   = XW'(1);
                delta_d = delta_d - XW'(2);
            end
            if (fill_here) begin
                delta_d = delta_d + XW'(1);
            end
            nxt_l = base_l + inc_l;
            nxt_d = base_d + delta_d;
            if (nxt_l > L_MAX) nxt_l = L_MAX;
            if (nxt_d > D_MAX) nxt_d = D_MAX;
            if (nxt_d < D_MIN) nxt_d = D_MIN;
            st_d.live[b] = nxt_l[CNT_W-1:0];
            st_d.dl[b]   = nxt_d[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live_o = st_q.live;
    assign dl_o   = st_q.dl;

    for (genvar g = 0; g < NUM_BINS; g++) begin : g_chk
        // R3
        live_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !halve |=> live_o[g] >= $past(live_o[g]));
        // R2
        fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_v && fill_bin == BIN_W'(g) && !(hit_v && hit_bin == BIN_W'(g)) && !halve
             && $signed(dl_o[g]) != $signed(D_MAX[CNT_W-1:0]))
            |=> $signed(dl_o[g]) == $signed($past(dl_o[g])) + 1);
        // R5
        halve_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (halve && !fill_v && !hit_v) |=> live_o[g] == ($past(live_o[g]) >> 1));
    end
endmodule

// File: rtl/bin_summary.sv
module bin_summary
    import bin_learner_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int SW    = CNT_W + BIN_W + 3
) (
    input  logic [NUM_BINS-1:0][CNT_W-1:0] live_i,
    input  logic [NUM_BINS-1:0][CNT_W-1:0] dl_i,
    output logic signed [SW-1:0]           dl_min_o,
    output logic signed [SW-1:0]           dl_max_o,
    output logic signed [SW-1:0]           dl_sum_o,
    output logic signed [SW-1:0]           l_min_o,
    output logic signed [SW-1:0]           l_max_o,
    output logic signed [SW-1:0]           l_sum_o
);
    always_comb begin
        logic signed [SW-1:0] d, l;
        dl_min_o = $signed(SW'($signed(dl_i[0])));
        dl_max_o = dl_min_o;
        dl_sum_o = '0;
        l_min_o  = $signed(SW'(live_i[0]));
        l_max_o  = l_min_o;
        l_sum_o  = '0;
        for (int b = 0; b < NUM_BINS; b++) begin
            d = $signed(SW'($signed(dl_i[b])));
            l = $signed(SW'(live_i[b]));
            if (d < dl_min_o) dl_min_o = d;
            if (d > dl_max_o) dl_max_o = d;
            if (l < l_min_o)  l_min_o  = l;
            if (l > l_max_o)  l_max_o  = l;
            dl_sum_o = dl_sum_o + d;
            l_sum_o  = l_sum_o + l;
        end
    end
endmodule

// File: rtl/insert_decider.sv
module insert_decider
    import bin_learner_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int SW    = CNT_W + BIN_W + 3
) (
    input  logic                   evict_v,
    input  logic [TC_W-1:0]        tc,
    input  logic [UC_W-1:0]        uc,
    input  logic                   free_way,
    input  logic [CNT_W-1:0]       l_sel,
    input  logic [CNT_W-1:0]       dl_sel,
    input  logic signed [SW-1:0]   dl_min,
    input  logic signed [SW-1:0]   dl_max,
    input  logic signed [SW-1:0]   dl_sum,
    input  logic signed [SW-1:0]   l_min,
    input  logic signed [SW-1:0]   l_max,
    input  logic signed [SW-1:0]   l_sum,
    output decision_t              dec_o
);
    logic signed [SW-1:0] dl, l;
    logic above_mid, below_mid, heavy_dead, heavy_live, mostly_dead, skip_wanted;

    always_comb begin
        dl = $signed(SW'($signed(dl_sel)));
        l  = $signed(SW'(l_sel));
        above_mid   = (dl <<< 1) > (dl_min + dl_max);
        below_mid   = (l <<< 1) < (l_min + l_max);
        heavy_dead  = (dl <<< 2) > (dl_sum * SW'(3));
        heavy_live  = ((l <<< 2) > (l_sum * SW'(3))) && (uc != '0);
        mostly_dead = (dl - l * SW'(7)) > SW'(0);
        skip_wanted = (above_mid && below_mid) || heavy_dead;

        dec_o = '{bypass: 1'b0, age: AGE_EVICT_FIRST};
        if (!evict_v) begin
            dec_o = '{bypass: 1'b0, age: AGE_EVICT_FIRST};
        end else if (skip_wanted) begin
            dec_o = '{bypass: !free_way, age: AGE_EVICT_FIRST};
        end else if (heavy_live) begin
            dec_o = '{bypass: 1'b0, age: AGE_PROTECT};
        end else if (mostly_dead) begin
            dec_o = '{bypass: 1'b0, age: AGE_EVICT_FIRST};
        end else begin
            dec_o = '{bypass: 1'b0, age: (tc != '0) ? AGE_PROTECT : AGE_COLD};
        end
    end
endmodule

// File: rtl/bin_bypass_learner.sv
module bin_bypass_learner
    import bin_learner_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        obs_fill_valid,
    input  logic        obs_fill_tc,
    input  logic [1:0]  obs_fill_uc,
    input  logic        obs_hit_valid,
    input  logic        obs_hit_tc,
    input  logic [1:0]  obs_hit_uc,
    input  logic        halve_tick,
    input  logic        evict_valid,
    input  logic        evict_tc,
    input  logic [1:0]  evict_uc,
    input  logic        set_has_invalid,
    output logic        bypass,
    output logic [1:0]  ins_age
);
    localparam int SW = CNT_W + BIN_W + 3;

    logic [NUM_BINS-1:0][CNT_W-1:0] live, dl;
    logic signed [SW-1:0] dl_min, dl_max, dl_sum, l_min, l_max, l_sum;
    logic [BIN_W-1:0] ev_bin;
    decision_t dec;

    bin_counter_bank #(.CNT_W(CNT_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_v   (obs_fill_valid),
        .fill_bin (make_bin(obs_fill_tc, obs_fill_uc)),
        .hit_v    (obs_hit_valid),
        .hit_bin  (make_bin(obs_hit_tc, obs_hit_uc)),
        .halve    (halve_tick),
        .live_o   (live),
        .dl_o     (dl)
    );

    bin_summary #(.CNT_W(CNT_W), .SW(SW)) u_sum (
        .live_i   (live),
        .dl_i     (dl),
        .dl_min_o (dl_min),
        .dl_max_o (dl_max),
        .dl_sum_o (dl_sum),
        .l_min_o  (l_min),
        .l_max_o  (l_max),
        .l_sum_o  (l_sum)
    );

    assign ev_bin = make_bin(evict_tc, evict_uc);

    insert_decider #(.CNT_W(CNT_W), .SW(SW)) u_dec (
        .evict_v  (evict_valid),
        .tc       (evict_tc),
        .uc       (evict_uc),
        .free_way (set_has_invalid),
        .l_sel    (live[ev_bin]),
        .dl_sel   (dl[ev_bin]),
        .dl_min   (dl_min),
        .dl_max   (dl_max),
        .dl_sum   (dl_sum),
        .l_min    (l_min),
        .l_max    (l_max),
        .l_sum    (l_sum),
        .dec_o    (dec)
    );

    assign bypass  = dec.bypass;
    assign ins_age = dec.age;

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evict_valid |-> (!bypass && ins_age == 2'd0));
    // R8
    free_way_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_has_invalid |-> !bypass);
    // R12
    bypass_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> ins_age == 2'd0);
    // R9
    cold_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && !bypass && ins_age == 2'd3 && evict_tc == 1'b0) |-> evict_uc != 2'd0);
endmodule

// File: tb/bin_bypass_learner_test.sv
`timescale 1ns/1ps
module bin_bypass_learner_test;
    localparam int LMAX = 4095;
    localparam int DMAX = 2047;
    localparam int DMIN = -2048;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic obs_fill_valid = 0, obs_fill_tc = 0, obs_hit_valid = 0, obs_hit_tc = 0;
    logic [1:0] obs_fill_uc = 0, obs_hit_uc = 0, evict_uc = 0;
    logic halve_tick = 0, evict_valid = 0, evict_tc = 0, set_has_invalid = 0;
    logic bypass;
    logic [1:0] ins_age;

    bin_bypass_learner uut (.*);

    typedef struct {
        bit         byp;
        bit [1:0]   age;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int live_m[8];
    int dl_m[8];
    int total = 0, bad = 0;
    bit done = 0;
    string note = "";

    function automatic exp_t predict(int tc, int uc, bit inv);
        exp_t e;
        int b, dl, l, dmin, dmax, dsum, lmin, lmax, lsum;
        bit mid, quart;
        b = tc * 4 + uc;  // R1 bin index
        dl = dl_m[b]; l = live_m[b];
        dmin = dl_m[0]; dmax = dl_m[0]; lmin = live_m[0]; lmax = live_m[0];
        dsum = 0; lsum = 0;
        for (int i = 0; i < 8; i++) begin
            if (dl_m[i] < dmin) dmin = dl_m[i];
            if (dl_m[i] > dmax) dmax = dl_m[i];
            if (live_m[i] < lmin) lmin = live_m[i];
            if (live_m[i] > lmax) lmax = live_m[i];
            dsum += dl_m[i]; lsum += live_m[i];
        end
        mid   = (2 * dl > dmin + dmax) && (2 * l < lmin + lmax);
        quart = (4 * dl > 3 * dsum);
        if ((mid || quart) && inv) begin e.byp = 0; e.age = 0; e.tag = "R8"; end
        else if (quart)            begin e.byp = 1; e.age = 0; e.tag = "R7"; end
        else if (mid)              begin e.byp = 1; e.age = 0; e.tag = "R6"; end
        else if (4 * l > 3 * lsum && uc != 0) begin e.byp = 0; e.age = 3; e.tag = "R9"; end
        else if (dl - 7 * l > 0)   begin e.byp = 0; e.age = 0; e.tag = "R10"; end
        else begin e.byp = 0; e.age = (tc != 0) ? 2'd3 : 2'd1; e.tag = "R11"; end
        return e;
    endfunction

    task automatic model_update(bit fv, int fb, bit hv, int hb, bit hf);
        for (int i = 0; i < 8; i++) begin
            if (hf) begin live_m[i] = live_m[i] >>> 1; dl_m[i] = dl_m[i] >>> 1; end  // R5
            if (hv && hb == i) begin live_m[i] += 1; dl_m[i] -= 2; end              // R3
            if (fv && fb == i) dl_m[i] += 1;                                        // R2
            if (live_m[i] > LMAX) live_m[i] = LMAX;                                 // R4
            if (dl_m[i] > DMAX) dl_m[i] = DMAX;
            if (dl_m[i] < DMIN) dl_m[i] = DMIN;
        end
    endtask

    // driver: one cycle of stimulus, expected decision pushed to the scoreboard
    task automatic cyc(bit fv, int fb, bit hv, int hb, bit hf, bit ev, int eb, bit inv);
        @(posedge clk); #1;
        obs_fill_valid = fv; {obs_fill_tc, obs_fill_uc} = 3'(fb);
        obs_hit_valid  = hv; {obs_hit_tc, obs_hit_uc}   = 3'(hb);
        halve_tick = hf;
        evict_valid = ev; {evict_tc, evict_uc} = 3'(eb);
        set_has_invalid = inv;
        if (ev) exp_q.push_back(predict(eb / 4, eb % 4, inv));
        model_update(fv, fb, hv, hb, hf);
    endtask

    task automatic ev(int eb, bit inv);
        cyc(0, 0, 0, 0, 0, 1, eb, inv);
    endtask

    task automatic ev_all();
        for (int b = 0; b < 8; b++) begin ev(b, 0); ev(b, 1); end
    endtask

    // monitor: compares design outputs against scoreboard at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (evict_valid) begin
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R12 (%s): unexpected decision bypass=%0d age=%0d expected none", note, bypass, ins_age);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (bypass !== e.byp || ins_age !== e.age) begin
                        bad++;
                        $display("FAIL %s (%s) bin=%0d: bypass=%0d age=%0d expected bypass=%0d age=%0d",
                                 e.tag, note, {evict_tc, evict_uc}, bypass, ins_age, e.byp, e.age);
                    end
                end
            end else begin
                total++;
                if (bypass !== 1'b0 || ins_age !== 2'd0) begin
                    bad++;
                    $display("FAIL R12 (%s): idle bypass=%0d age=%0d expected 0 0", note, bypass, ins_age);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: run incomplete, actual hung expected finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin live_m[i] = 0; dl_m[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        note = "R1 reset state, default ages R11";
        ev_all();

        note = "R2 fills raise dead count, R7 R8";
        for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 0, 0, 0, 0);
        ev(1, 0); ev(1, 1); ev(0, 0);

        note = "R3 hits raise live, R9";
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 6, 0, 0, 0, 0);
        ev_all();
        note = "R3 fill and hit same bin same cycle";
        cyc(1, 6, 1, 6, 0, 0, 0, 0);
        ev_all();

        note = "R12 event and decision same cycle";
        cyc(1, 3, 0, 0, 0, 1, 3, 0);
        cyc(1, 3, 1, 2, 0, 1, 3, 0);
        ev(3, 0); ev(2, 0);

        note = "R10 mostly dead bin";
        for (int i = 0; i < 20; i++) cyc(1, 4, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 4, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 7, 0, 0, 0, 0);
        ev_all();

        note = "R5 halving";
        for (int i = 0; i < 3; i++) cyc(1, 0, 1, 5, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 0, 0);
        ev_all();
        cyc(1, 5, 0, 0, 1, 1, 5, 0);
        ev_all();

        note = "R4 dead-minus-live low saturation";
        for (int i = 0; i < 1100; i++) cyc(0, 0, 1, 5, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(1, 5, 0, 0, 0, 0, 0, 0);
        ev_all();
        note = "R4 dead-minus-live high saturation";
        for (int i = 0; i < 2100; i++) cyc(1, 2, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 2, 0, 0, 0, 0);
        ev_all();
        note = "R4 live saturation";
        for (int i = 0; i < 4100; i++) cyc(0, 0, 1, 7, 0, 0, 0, 0);
        ev_all();
        note = "R4 R5 halving saturated counters";
        cyc(0, 0, 0, 0, 1, 0, 0, 0);
        ev_all();

        note = "R6 midpoint test";
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1, 0, 0, 0);
        ev_all();

        note = "random mix R1 to R12";
        for (int i = 0; i < 4000; i++) begin
            cyc($urandom_range(0, 1) == 1, $urandom_range(0, 7),
                $urandom_range(0, 2) == 0, $urandom_range(0, 7),
                $urandom_range(0, 63) == 0,
                $urandom_range(0, 3) != 0, $urandom_range(0, 7),
                $urandom_range(0, 3) == 0);
        end

        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        @(posedge clk); #1;
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R12: %0d decisions missing, expected 0", exp_q.size());
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule